// File: doc/BRIEF.md
# Address-Masked GPIO Register Bank

This block is a memory-mapped controller for eight general-purpose I/O lines on a simple byte-wide register bus. Each line is configured as an input or an output. A data port covers the whole low kilobyte of the address space. In every data access, address bits [9:2] act as a per-line mask. Software can therefore set, clear or sample any chosen group of lines with a single access, without a read-modify-write sequence. A data write lands only on lines that are already outputs.

Pad inputs pass through a two-flop synchroniser. The synchronised values feed the data port and an interrupt-sense unit. For each line, the sense unit detects a level, a single edge or both edges. It keeps a raw status and a masked status, and it drives one combined interrupt output. Software acknowledges latched edge events through a write-only clear register. The driven values, the output enables and the pad inputs appear at the block edge as plain vectors.

Top module: `gpio_mask_bank`

## Requirements
- R1: After a synchronous reset every configuration register is 0: direction, stored output value, sense, both-edges, polarity and enable. So `pin_oe` is 0, `pin_out` is 0 and `irq` is 0.
- R2: The direction register at offset 0x400 reads back the value last written. Bit n = 1 makes line n an output, and `pin_oe[n]` follows that bit.
- R3: A read with address bits [11:10] = 00 is a data read. Bit n returns the line value when address bit n+2 is 1 and returns 0 otherwise. The line value is the stored output for an output line and the synchronised pad for an input line.
- R4: A data write changes the stored output of line n only when address bit n+2 is 1. Address bits [1:0] are not decoded.
- R5: A data write to a line configured as an input leaves its stored output unchanged. When that line later becomes an output, it drives its earlier stored value.
- R6: A pad change is visible to a data read after two clock edges and not after one.
- R7: The sense (0x404, 1 = level), both-edges (0x408), polarity (0x40C, 1 = high or rising) and enable (0x410) registers read back what was written.
- R8: In level mode the raw status bit (0x414) is 1 exactly while the synchronised pad equals the polarity bit. It is not latched, and the clear register does not affect it.
- R9: In edge mode with both-edges 0, the raw status bit latches only on the edge selected by polarity. With both-edges 1 it latches on either edge, and polarity is ignored.
- R10: Writing 1 to bit n of the write-only clear register at 0x41C clears the latched edge status of line n. The clear register reads as 0.
- R11: The masked status (0x418) equals raw status AND enable, and `irq` is 1 exactly when any masked bit is 1.
- R12: Reads of unmapped offsets return 0. Writes to unmapped offsets, or to the status registers at 0x414 and 0x418, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data, one bit per line |
| bus_rdata | output | 8 | Read data, valid in the same cycle as the read strobe |
| pad_in | input | 8 | Raw pad input values |
| pin_out | output | 8 | Driven output values |
| pin_oe | output | 8 | Output enables, one per line |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: eight lines and two synchroniser stages. With eight lines, every address-mask bit from 2 to 9 can be reached. With two stages, the exact cycle in which a pad change becomes readable can be checked. A vector table covers masked reads and writes, writes to input lines, readback of the configuration registers and unmapped offsets. Directed sequences then drive the pads to check level sense, single-edge and both-edge latching, clearing, and gating by the enable register.

// File: rtl/gpbank_pkg.sv
// Package gpbank_pkg: address map and access decode shared by the GPIO bank.
// Assumes a 12-bit byte offset; the data port is the whole low kilobyte.
package gpbank_pkg;

    localparam int unsigned BANK_AW = 12;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_SENSE,
        SEL_BOTH,
        SEL_POL,
        SEL_EN,
        SEL_RAW,
        SEL_MASKED,
        SEL_CLR
    } bank_sel_e;

    localparam logic [BANK_AW-1:0] OFS_DIR    = 12'h400;
    localparam logic [BANK_AW-1:0] OFS_SENSE  = 12'h404;
    localparam logic [BANK_AW-1:0] OFS_BOTH   = 12'h408;
    localparam logic [BANK_AW-1:0] OFS_POL    = 12'h40C;
    localparam logic [BANK_AW-1:0] OFS_EN     = 12'h410;
    localparam logic [BANK_AW-1:0] OFS_RAW    = 12'h414;
    localparam logic [BANK_AW-1:0] OFS_MASKED = 12'h418;
    localparam logic [BANK_AW-1:0] OFS_CLR    = 12'h41C;

    // Map a byte offset to the register it selects.
    function automatic bank_sel_e decode_addr(input logic [BANK_AW-1:0] a);
        if (a[BANK_AW-1:BANK_AW-2] == 2'b00) return SEL_DATA;
        case (a)
            OFS_DIR:    return SEL_DIR;
            OFS_SENSE:  return SEL_SENSE;
            OFS_BOTH:   return SEL_BOTH;
            OFS_POL:    return SEL_POL;
            OFS_EN:     return SEL_EN;
            OFS_RAW:    return SEL_RAW;
            OFS_MASKED: return SEL_MASKED;
            OFS_CLR:    return SEL_CLR;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpbank_sync.sv
// Module gpbank_sync: multi-flop synchroniser for the pad inputs.
// Assumes STAGES >= 2; all stages reset to 0.
module gpbank_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pad values through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpbank_cfg.sv
// Module gpbank_cfg: direction, output and interrupt configuration registers.
// Assumes write decode is done by the caller; data writes are gated per line
// by the address mask and by the current direction.
module gpbank_cfg
    import gpbank_pkg::*;
#(
    parameter int unsigned LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  bank_sel_e        sel,
    input  logic [LINES-1:0] line_mask,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] dir_q,
    output logic [LINES-1:0] out_q,
    output logic [LINES-1:0] sense_q,
    output logic [LINES-1:0] both_q,
    output logic [LINES-1:0] pol_q,
    output logic [LINES-1:0] en_q
);
    logic [LINES-1:0] take;

    // Lines a data write may touch: masked in by address and already outputs.
    assign take = line_mask & dir_q;

    // Register writes; everything clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            out_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            en_q    <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DATA:  out_q   <= (out_q & ~take) | (wdata & take);
                SEL_DIR:   dir_q   <= wdata;
                SEL_SENSE: sense_q <= wdata;
                SEL_BOTH:  both_q  <= wdata;
                SEL_POL:   pol_q   <= wdata;
                SEL_EN:    en_q    <= wdata;
                default:   ;
            endcase
        end
    end

    // R1: one cycle after reset, all configuration is zero
    a_r1_reset_clear: assert property (@(posedge clk)
        !$past(rst_n) |-> (dir_q == '0 && out_q == '0 && en_q == '0 &&
                           sense_q == '0 && both_q == '0 && pol_q == '0));

    // R5: stored output bits change only where a data write hit an output line
    a_r5_input_lines_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((out_q ^ $past(out_q)) &
            ~($past(dir_q) & $past(line_mask) &
              {LINES{$past(wr_en) && $past(sel) == SEL_DATA}})) == '0);

endmodule

// File: rtl/gpbank_irq_sense.sv
// Module gpbank_irq_sense: per-line level/edge detection, status and request.
// Assumes pad_s is already synchronised. Edge events latch until cleared;
// a new edge in the same cycle as a clear wins.
module gpbank_irq_sense #(
    parameter int unsigned LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pad_s,
    input  logic [LINES-1:0] sense,
    input  logic [LINES-1:0] both,
    input  logic [LINES-1:0] pol,
    input  logic [LINES-1:0] en,
    input  logic             clr_we,
    input  logic [LINES-1:0] clr_bits,
    output logic [LINES-1:0] raw,
    output logic [LINES-1:0] masked,
    output logic             irq
);
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] latch_q;
    logic [LINES-1:0] hit;
    logic [LINES-1:0] clr_v;

    assign clr_v = clr_we ? clr_bits : '0;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic rise;
        logic fall;
        // Edge detection on this line against the previous sample.
        assign rise   = pad_s[i] & ~prev_q[i];
        assign fall   = ~pad_s[i] & prev_q[i];
        assign hit[i] = ~sense[i] & (both[i] ? (rise | fall) : (pol[i] ? rise : fall));
        // Level mode shows the live comparison; edge mode shows the latch.
        assign raw[i] = sense[i] ? (pad_s[i] ~^ pol[i]) : latch_q[i];

        // R10: a clear with no simultaneous edge empties the latch
        a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_bits[i] && !hit[i]) |=> !latch_q[i]);

        // R9: the latch only rises on a detected edge
        a_r9_latch_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(latch_q[i]) |-> $past(hit[i]));
    end

    // Track previous pad values and latch edge events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= pad_s;
            latch_q <= (latch_q & ~clr_v) | hit;
        end
    end

    assign masked = raw & en;
    assign irq    = |masked;

endmodule

// File: rtl/gpio_mask_bank.sv
// Module gpio_mask_bank: address-masked GPIO register bank with interrupt sense.
// Assumes a single-cycle byte bus: writes land on the clock edge of the strobe,
// read data is combinational in the strobe cycle. LINES must not exceed 8 so
// the mask fits in address bits [9:2].
module gpio_mask_bank
    import gpbank_pkg::*;
#(
    parameter int unsigned LINES       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [BANK_AW-1:0] bus_addr,
    input  logic [LINES-1:0]   bus_wdata,
    output logic [LINES-1:0]   bus_rdata,
    input  logic [LINES-1:0]   pad_in,
    output logic [LINES-1:0]   pin_out,
    output logic [LINES-1:0]   pin_oe,
    output logic               irq
);
    localparam int unsigned MASK_LO = 2;
    localparam int unsigned MASK_HI = MASK_LO + LINES - 1;

    bank_sel_e        sel;
    logic [LINES-1:0] line_mask;
    logic             wr_en;
    logic [LINES-1:0] pad_s;
    logic [LINES-1:0] dir_q, out_q, sense_q, both_q, pol_q, en_q;
    logic [LINES-1:0] raw, masked;
    logic [LINES-1:0] line_val;

    assign sel       = decode_addr(bus_addr);
    assign line_mask = bus_addr[MASK_HI:MASK_LO];
    assign wr_en     = bus_en & bus_we;

    gpbank_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_s)
    );

    gpbank_cfg #(.LINES(LINES)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .sel       (sel),
        .line_mask (line_mask),
        .wdata     (bus_wdata),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .sense_q   (sense_q),
        .both_q    (both_q),
        .pol_q     (pol_q),
        .en_q      (en_q)
    );

    gpbank_irq_sense #(.LINES(LINES)) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_s    (pad_s),
        .sense    (sense_q),
        .both     (both_q),
        .pol      (pol_q),
        .en       (en_q),
        .clr_we   (wr_en && sel == SEL_CLR),
        .clr_bits (bus_wdata),
        .raw      (raw),
        .masked   (masked),
        .irq      (irq)
    );

    // Value seen on each line: driven value for outputs, synchronised pad otherwise.
    assign line_val = (dir_q & out_q) | (~dir_q & pad_s);

    // Read-data multiplexer; unmapped and write-only offsets return 0.
    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            case (sel)
                SEL_DATA:   bus_rdata = line_val & line_mask;
                SEL_DIR:    bus_rdata = dir_q;
                SEL_SENSE:  bus_rdata = sense_q;
                SEL_BOTH:   bus_rdata = both_q;
                SEL_POL:    bus_rdata = pol_q;
                SEL_EN:     bus_rdata = en_q;
                SEL_RAW:    bus_rdata = raw;
                SEL_MASKED: bus_rdata = masked;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;

    // R3: a data read never returns a line outside the address mask
    a_r3_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && sel == SEL_DATA) |-> (bus_rdata & ~line_mask) == '0);

    // R11: an interrupt request needs at least one enabled line
    a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> en_q != '0);

    // R2: output enables move only after a direction write
    a_r2_oe_from_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(pin_oe)) |-> ($past(wr_en) && $past(sel) == SEL_DIR));

endmodule

// File: tb/sim_gpio_mask_bank.sv
// Bench for gpio_mask_bank: vector table walk, then directed reset,
// synchroniser and interrupt-sense sequences.
module sim_gpio_mask_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pad_in = 8'hA5;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_mask_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    // Vector: {write, offset, wdata, expected read, requirement number}
    localparam int NV = 24;
    localparam logic [32:0] VEC [NV] = '{
        {1'b1, 12'h400, 8'h0F, 8'h00, 4'd2},   // R2 lines 0-3 outputs
        {1'b0, 12'h400, 8'h00, 8'h0F, 4'd2},   // R2
        {1'b1, 12'h3FC, 8'hFF, 8'h00, 4'd4},   // R4 all-mask write
        {1'b0, 12'h3FC, 8'h00, 8'hAF, 4'd3},   // R3 outputs F, pads A
        {1'b1, 12'h004, 8'h00, 8'h00, 4'd4},   // R4 line 0 only
        {1'b0, 12'h3FC, 8'h00, 8'hAE, 4'd4},   // R4
        {1'b0, 12'h024, 8'h00, 8'h08, 4'd3},   // R3 mask lines 0,3
        {1'b0, 12'h014, 8'h00, 8'h04, 4'd3},   // R3 mask lines 0,2
        {1'b1, 12'h3C0, 8'hFF, 8'h00, 4'd5},   // R5 write to input lines
        {1'b1, 12'h400, 8'hFF, 8'h00, 4'd5},   // R5 all outputs
        {1'b0, 12'h3FC, 8'h00, 8'h0E, 4'd5},   // R5 upper lines kept 0
        {1'b1, 12'h404, 8'h33, 8'h00, 4'd7},   // R7
        {1'b0, 12'h404, 8'h00, 8'h33, 4'd7},   // R7
        {1'b1, 12'h408, 8'h0C, 8'h00, 4'd7},   // R7
        {1'b0, 12'h408, 8'h00, 8'h0C, 4'd7},   // R7
        {1'b1, 12'h40C, 8'h81, 8'h00, 4'd7},   // R7
        {1'b0, 12'h40C, 8'h00, 8'h81, 4'd7},   // R7
        {1'b1, 12'h410, 8'h5A, 8'h00, 4'd7},   // R7
        {1'b0, 12'h410, 8'h00, 8'h5A, 4'd7},   // R7
        {1'b1, 12'h420, 8'hFF, 8'h00, 4'd12},  // R12 unmapped write
        {1'b0, 12'h420, 8'h00, 8'h00, 4'd12},  // R12 unmapped read
        {1'b0, 12'h41C, 8'h00, 8'h00, 4'd10},  // R10 clear reads 0
        {1'b0, 12'h400, 8'h00, 8'hFF, 4'd12},  // R12 dir untouched
        {1'b0, 12'h800, 8'h00, 8'h00, 4'd12}   // R12 unmapped high
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pad(input logic [7:0] p);
        @(negedge clk);
        pad_in = p;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        idle(4);
        rst_n = 1'b1;
        idle(4);

        // R1 reset state
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pin_out", pin_out, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        rd(12'h400, v); check("R1 dir", v, 8'h00);
        rd(12'h410, v); check("R1 enable", v, 8'h00);
        rd(12'h3FC, v); check("R3 all inputs read pads", v, 8'hA5);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][32]) begin
                wr(VEC[i][31:20], VEC[i][19:12]);
            end else begin
                rd(VEC[i][31:20], v);
                checks++;
                if (v !== VEC[i][11:4]) begin
                    failures++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h",
                             VEC[i][3:0], i, v, VEC[i][11:4]);
                end
            end
        end
        check("R2 pin_oe", pin_oe, 8'hFF);
        check("R5 pin_out keeps earlier value", pin_out, 8'h0E);

        // R1 reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        check("R1 pin_oe after reset", pin_oe, 8'h00);
        check("R1 pin_out after reset", pin_out, 8'h00);
        rd(12'h40C, v); check("R1 polarity after reset", v, 8'h00);
        idle(4);

        // R6 two-stage synchroniser latency
        set_pad(8'h5A);
        rd(12'h3FC, v); check("R6 after one edge", v, 8'hA5);
        rd(12'h3FC, v); check("R6 after two edges", v, 8'h5A);

        // R8 level sense on line 2, high polarity
        wr(12'h404, 8'h04);
        wr(12'h40C, 8'h04);
        wr(12'h410, 8'h04);
        rd(12'h414, v); check("R8 level low", v & 8'h04, 8'h00);
        check("R11 irq idle", {7'b0, irq}, 8'h00);
        set_pad(8'h5E); idle(4);
        rd(12'h414, v); check("R8 level high", v & 8'h04, 8'h04);
        rd(12'h418, v); check("R11 masked level", v, 8'h04);
        check("R11 irq on level", {7'b0, irq}, 8'h01);
        wr(12'h41C, 8'h04);
        rd(12'h414, v); check("R8 clear ignores level", v & 8'h04, 8'h04);
        set_pad(8'h5A); idle(4);
        rd(12'h414, v); check("R8 not latched", v & 8'h04, 8'h00);
        check("R11 irq drops", {7'b0, irq}, 8'h00);

        // R9 rising edge on line 1, enable held off
        set_pad(8'h58); idle(4);
        wr(12'h404, 8'h00);
        wr(12'h40C, 8'h02);
        wr(12'h410, 8'h00);
        wr(12'h41C, 8'hFF);
        rd(12'h414, v); check("R10 cleared before edge", v & 8'h02, 8'h00);
        set_pad(8'h5A); idle(4);
        rd(12'h414, v); check("R9 rising latched", v & 8'h02, 8'h02);
        rd(12'h418, v); check("R11 masked off", v & 8'h02, 8'h00);
        check("R11 irq gated", {7'b0, irq}, 8'h00);
        wr(12'h410, 8'h02);
        check("R11 irq after enable", {7'b0, irq}, 8'h01);
        wr(12'h414, 8'h00);
        rd(12'h414, v); check("R12 status write ignored", v & 8'h02, 8'h02);
        wr(12'h41C, 8'h02);
        rd(12'h414, v); check("R10 edge cleared", v & 8'h02, 8'h00);
        check("R10 irq cleared", {7'b0, irq}, 8'h00);
        set_pad(8'h58); idle(4);
        rd(12'h414, v); check("R9 falling ignored", v & 8'h02, 8'h00);

        // R9 both edges on line 3, polarity ignored
        wr(12'h408, 8'h08);
        wr(12'h40C, 8'h00);
        wr(12'h410, 8'h08);
        wr(12'h41C, 8'hFF);
        set_pad(8'h50); idle(4);
        rd(12'h414, v); check("R9 both: falling", v & 8'h08, 8'h08);
        wr(12'h41C, 8'h08);
        rd(12'h414, v); check("R10 both cleared", v & 8'h08, 8'h00);
        set_pad(8'h58); idle(4);
        rd(12'h414, v); check("R9 both: rising", v & 8'h08, 8'h08);
        check("R11 irq both", {7'b0, irq}, 8'h01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule